// File: doc/BRIEF.md
# Masked Four-Source Priority Interrupt Controller

The block gathers four interrupt request lines into a bank of sticky pending bits, gates them with a per-source enable mask and picks the most urgent surviving source with a fixed-priority encoder. Source 0 is the most urgent and source 3 the least. A single interrupt line to the processor is raised only while a global enable flag is set and at least one unmasked source is pending.

When the processor acknowledges, the block drives an 8-bit vector whose two low bits carry the encoded source number and whose other bits are zero, together with an output-enable that stands in for a tri-state bus driver. Acknowledging also drops the global enable, so no further interrupt is signalled until software turns it back on. Software manages the block through a small write port that sets or clears mask bits, clears pending bits and writes the global enable.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all pending bits, all mask bits and the global enable are 0; `irq_o` and `vec_oe_o` are low and an acknowledge then yields vector 0x00.
- R2: A request input high at a rising edge sets its pending bit at that edge, and the bit stays set after the request drops.
- R3: A write with `wr_sel_i` = 2 clears each pending bit whose `wr_data_i` bit is 1; if that source's request is high in the same cycle, the bit stays set.
- R4: A write with `wr_sel_i` = 0 sets the mask bits selected by `wr_data_i`, `wr_sel_i` = 1 clears them; a mask bit of 1 lets its source through, a mask bit of 0 hides it from both `irq_o` and the vector.
- R5: `irq_o` is 1 exactly when the global enable is 1 and at least one pending bit with its mask bit set exists.
- R6: Among unmasked pending sources the lowest index wins, encoded as source 0 = 00, 1 = 01, 2 = 10, 3 = 11.
- R7: While `ack_i` is high, `vec_o` equals the winning code in bits 1:0 with bits 7:2 zero; with nothing unmasked pending it is 0x00.
- R8: `vec_oe_o` follows `ack_i`; while it is low `vec_o` is 0x00.
- R9: `ack_i` high at a rising edge clears the global enable at that edge, taking precedence over a software enable write in the same cycle.
- R10: A write with `wr_sel_i` = 3 loads the global enable from `wr_data_i` bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 4 | Interrupt request lines, bit 0 most urgent |
| wr_en_i | input | 1 | Software write strobe |
| wr_sel_i | input | 2 | Write operation: 0 mask set, 1 mask clear, 2 pending clear, 3 global enable |
| wr_data_i | input | 4 | Bit selector for the operation, bit 0 is the enable value for operation 3 |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector address, valid while acknowledged |
| vec_oe_o | output | 1 | Drive enable for the vector bus |

## Verification
The bench aims at the collisions: a pending clear landing in the same cycle as a fresh request (a design that let the clear win would lose an interrupt), and an acknowledge coinciding with a software enable (a design that let software win would re-arm the line mid-service). It also checks that masking hides a source from the vector as well as from the line, since a design masking only the line would vector to a disabled source, and it probes every single-source and multi-source priority case so an inverted or shifted code shows up as a wrong vector.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  typedef enum logic [1:0] {
    OP_MASK_SET = 2'd0,
    OP_MASK_CLR = 2'd1,
    OP_PEND_CLR = 2'd2,
    OP_GLB_EN   = 2'd3
  } wr_op_e;

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);

  function automatic logic next_bit(input logic cur, input logic set, input logic clr);
    // a request beats a clear in the same cycle
    return set | (cur & ~clr);
  endfunction

  for (genvar i = 0; i < N_SRC; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n) pend_o[i] <= 1'b0;
      else        pend_o[i] <= next_bit(pend_o[i], req_i[i], clr_i[i]);
    end
  end

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [N_SRC-1:0] wr_data_i,
  input  logic             ack_i,
  output logic [N_SRC-1:0] mask_o,
  output logic             glb_en_o,
  output logic [N_SRC-1:0] pend_clr_o
);

  wr_op_e op;
  logic   do_set, do_clr, do_pclr, do_en;

  assign op      = wr_op_e'(wr_sel_i);
  assign do_set  = wr_en_i && (op == OP_MASK_SET);
  assign do_clr  = wr_en_i && (op == OP_MASK_CLR);
  assign do_pclr = wr_en_i && (op == OP_PEND_CLR);
  assign do_en   = wr_en_i && (op == OP_GLB_EN);

  assign pend_clr_o = do_pclr ? wr_data_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o <= '0;
    end else if (do_set) begin
      mask_o <= mask_o | wr_data_i;
    end else if (do_clr) begin
      mask_o <= mask_o & ~wr_data_i;
    end
  end

  // acknowledge entering service drops the enable ahead of software
  always_ff @(posedge clk) begin
    if (!rst_n)     glb_en_o <= 1'b0;
    else if (ack_i) glb_en_o <= 1'b0;
    else if (do_en) glb_en_o <= wr_data_i[0];
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N_SRC  = 4,
  parameter int CODE_W = 2
) (
  input  logic [N_SRC-1:0]  act_i,
  output logic [N_SRC-1:0]  grant_o,
  output logic [CODE_W-1:0] code_o,
  output logic              any_o
);

  function automatic logic [CODE_W-1:0] first_idx(input logic [N_SRC-1:0] v);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (v[i]) c = CODE_W'(i);
    end
    return c;
  endfunction

  // each stage passes priority on only when no lower index is active
  logic [N_SRC:0] pass;
  assign pass[0] = 1'b1;
  for (genvar i = 0; i < N_SRC; i++) begin : g_chain
    assign grant_o[i]  = pass[i] & act_i[i];
    assign pass[i+1]   = pass[i] & ~act_i[i];
  end

  assign any_o  = ~pass[N_SRC];
  assign code_o = first_idx(act_i);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_SRC = 4,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [N_SRC-1:0] wr_data_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_oe_o
);

  localparam int CODE_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0]  pend, mask, pend_clr, active, grant;
  logic [CODE_W-1:0] code;
  logic              glb_en, any_act;

  irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (req_i),
    .clr_i (pend_clr),
    .pend_o(pend)
  );

  irq_ctrl_regs #(.N_SRC(N_SRC)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .ack_i     (ack_i),
    .mask_o    (mask),
    .glb_en_o  (glb_en),
    .pend_clr_o(pend_clr)
  );

  assign active = pend & mask;

  irq_prio_enc #(.N_SRC(N_SRC), .CODE_W(CODE_W)) u_enc (
    .act_i  (active),
    .grant_o(grant),
    .code_o (code),
    .any_o  (any_act)
  );

  assign irq_o    = glb_en & any_act;
  assign vec_oe_o = ack_i;
  assign vec_o    = ack_i ? VEC_W'(code) : '0;

endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int N_SRC  = 4,
  parameter int VEC_W  = 8,
  parameter int CODE_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] req_i,
  input logic             ack_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_oe_o,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] mask,
  input logic [N_SRC-1:0] pend_clr,
  input logic [N_SRC-1:0] active,
  input logic [N_SRC-1:0] grant,
  input logic             glb_en
);

  // R2
  req_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(req_i)) == $past(req_i)));

  // R3
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend) & ~pend & ~$past(pend_clr)) == '0));

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (glb_en && ((pend & mask) != '0)));

  // R6
  grant_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (((grant - 1'b1) & active) == '0));

  // R7
  vec_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_o[VEC_W-1:CODE_W] == '0);

  // R8
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_oe_o |-> (vec_o == '0));

  // R9
  ack_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !glb_en);

endmodule

bind prio_irq_ctrl prio_irq_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W), .CODE_W(CODE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_i   (req_i),
  .ack_i   (ack_i),
  .irq_o   (irq_o),
  .vec_o   (vec_o),
  .vec_oe_o(vec_oe_o),
  .pend    (pend),
  .mask    (mask),
  .pend_clr(pend_clr),
  .active  (active),
  .grant   (grant),
  .glb_en  (glb_en)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_i = '0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = '0;
  logic [3:0] wr_data_i = '0;
  logic       ack_i = 1'b0;
  logic       irq_o;
  logic [7:0] vec_o;
  logic       vec_oe_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .ack_i(ack_i),
    .irq_o(irq_o), .vec_o(vec_o), .vec_oe_o(vec_oe_o)
  );

  // behavioural reference state
  int m_pend, m_mask, m_en;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_mask = 0; m_en = 0;
    end else begin
      if (wr_en_i && wr_sel_i == 2) m_pend = m_pend & ~int'(wr_data_i);
      m_pend = m_pend | int'(req_i);
      if (wr_en_i && wr_sel_i == 0) m_mask = m_mask | int'(wr_data_i);
      if (wr_en_i && wr_sel_i == 1) m_mask = m_mask & ~int'(wr_data_i);
      if (ack_i) m_en = 0;
      else if (wr_en_i && wr_sel_i == 3) m_en = int'(wr_data_i[0]);
    end
  end

  function automatic int ref_vec();
    int live = m_pend & m_mask;
    if (!ack_i) return 0;
    for (int k = 0; k < 4; k++) if (live[k]) return k;
    return 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      #5;
      check("R5 irq", int'(irq_o), ((m_en != 0) && ((m_pend & m_mask) != 0)) ? 1 : 0);
      check("R8 vec_oe", int'(vec_oe_o), int'(ack_i));
      check("R7 vec", int'(vec_o), ref_vec());
    end
  end

  task automatic drive(input logic [3:0] rq, input logic we, input logic [1:0] sel,
                       input logic [3:0] dat, input logic ak);
    @(negedge clk);
    req_i = rq; wr_en_i = we; wr_sel_i = sel; wr_data_i = dat; ack_i = ak;
  endtask

  task automatic idle_probe(input string tag, input int exp_vec);
    drive(4'h0, 1'b0, 2'd0, 4'h0, 1'b1);
    #6;
    check(tag, int'(vec_o), exp_vec);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #6;
    check("R1 irq after reset", int'(irq_o), 0);
    check("R1 oe after reset", int'(vec_oe_o), 0);
    idle_probe("R1 vec after reset", 0);

    drive(4'h0, 1'b1, 2'd0, 4'hF, 1'b0);
    drive(4'h0, 1'b1, 2'd3, 4'h1, 1'b0);
    drive(4'h8, 1'b0, 2'd0, 4'h0, 1'b0);
    drive(4'h0, 1'b0, 2'd0, 4'h0, 1'b0); #6;
    check("R2 R10 irq from held source 3", int'(irq_o), 1);
    idle_probe("R6 source 3 vector", 3);
    drive(4'h0, 1'b0, 2'd0, 4'h0, 1'b0); #6;
    check("R9 irq dropped after ack", int'(irq_o), 0);

    drive(4'h0, 1'b1, 2'd2, 4'h8, 1'b0);
    idle_probe("R3 cleared source gone", 0);

    drive(4'h6, 1'b0, 2'd0, 4'h0, 1'b0);
    idle_probe("R6 source 1 beats 2", 1);
    drive(4'h0, 1'b1, 2'd2, 4'h2, 1'b0);
    idle_probe("R6 source 2 after clear", 2);

    drive(4'h0, 1'b1, 2'd1, 4'h4, 1'b0);
    idle_probe("R4 masked source hidden", 0);
    drive(4'h0, 1'b1, 2'd0, 4'h4, 1'b0);
    idle_probe("R4 unmasked again", 2);

    drive(4'h0, 1'b1, 2'd2, 4'hF, 1'b0);
    drive(4'h2, 1'b1, 2'd2, 4'h2, 1'b0);
    idle_probe("R3 request beats clear", 1);

    drive(4'h1, 1'b1, 2'd3, 4'h1, 1'b1);
    drive(4'h0, 1'b0, 2'd0, 4'h0, 1'b0); #6;
    check("R9 ack beats enable write", int'(irq_o), 0);
    idle_probe("R6 source 0 vector", 0);

    drive(4'h0, 1'b1, 2'd3, 4'h1, 1'b0);
    drive(4'h0, 1'b0, 2'd0, 4'h0, 1'b0); #6;
    check("R10 enable on", int'(irq_o), 1);
    drive(4'h0, 1'b1, 2'd3, 4'h0, 1'b0);
    drive(4'h0, 1'b0, 2'd0, 4'h0, 1'b0); #6;
    check("R10 enable off", int'(irq_o), 0);

    for (int n = 0; n < 400; n++) begin
      drive(4'(($urandom % 5 == 0) ? $urandom : 0), 1'($urandom % 3 == 0),
            2'($urandom), 4'($urandom), 1'($urandom % 6 == 0));
    end
    drive(4'h0, 1'b0, 2'd0, 4'h0, 1'b0);
    @(negedge clk); #8;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule